// File: doc/BRIEF.md
# Indirectly Addressed Pin I/O Unit

This block drives and samples 22 general-purpose pins arranged in three groups: pins 10 to 17, pins 20 to 25 and pins 30 to 37. Software on the host's 8-bit I/O bus reaches the pin data only indirectly. It writes a register number to an index port, then reads or writes the selected data register through the data port next to it. The two ports sit at one of four relocatable addresses, and both can be switched off.

A separate configuration write interface carries an 8-bit address, 8-bit data and a strobe. It holds the placement and enable byte for the port pair, plus one byte per pin. Each pin byte chooses input or output, normal or inverted polarity, and ordinary or alternate-function control. A pin in alternate mode passes an external peripheral's output value and output enable straight to the pad.

Both host interfaces are plain strobe interfaces with no back-pressure. A write completes at the clock edge where its strobe is high. Read data is valid in the same cycle as the read strobe.

Top module: `idx_gpio`

## Requirements
- R1: After reset, every pin is a non-inverted input in ordinary mode, so `pad_oe` and `alt_sel` are all zero. All data latches hold 0, so `pad_out` is zero. The port pair is disabled.
- R2: A configuration write to address 0x03 sets the port-pair placement. Bit 7 is the enable. Bits 1:0 place the index/data ports: 0 gives 0xE0/0xE1, 1 gives 0xE2/0xE3, 2 gives 0xE4/0xE5 and 3 gives 0xEA/0xEB. A read of the index port returns the stored index, and only the selected pair responds.
- R3: While the enable bit is clear, bus writes to either port change nothing, and reads return 0x00. Once the pair is enabled again, the latches and index hold their earlier values.
- R4: The three data registers use index values 1, 2 and 3, for pins 10-17, 20-25 and 30-37 in that order. A pin's bit within its register is its number modulo 10. In every pin-wide vector, pin 10*(g+1)+b sits at bit 8*g+b.
- R5: An index outside 1..3 reads as 0x00, and a write through it changes no latch. In the second register, bits 7:6 read as 0 and are not stored. Vector bits 14 and 15 never drive.
- R6: The configuration byte addresses are 0xE0+b for pin 10+b, 0xE8+b for pin 20+b, and 0xF5+b for pin 30+b. A write to any other address changes no pin.
- R7: In a pin's configuration byte, bit 0 set makes the pin an input and clears its output enable. Bit 1 set inverts polarity. Bit 3 set selects alternate mode. All other bits are ignored.
- R8: For a pin not in alternate mode, `pad_out` equals its latch bit XOR its polarity bit. `pad_oe` is set when the pin is an output.
- R9: A data register read returns, for each pin, the pad level XOR polarity if the pin is an input, the latch bit if it is an output, and the raw pad level if it is in alternate mode.
- R10: A pin in alternate mode raises `alt_sel` and copies `alt_out` and `alt_oe` to `pad_out` and `pad_oe`. Its direction and polarity bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| io_addr | input | 8 | Host I/O bus address |
| io_wr | input | 1 | Host bus write strobe |
| io_rd | input | 1 | Host bus read strobe |
| io_wdata | input | 8 | Host bus write data |
| io_rdata | output | 8 | Host bus read data, valid with `io_rd`, zero otherwise |
| pad_in | input | 24 | Pad levels, bit 8*g+b for pin 10*(g+1)+b |
| alt_out | input | 24 | Alternate-function output values |
| alt_oe | input | 24 | Alternate-function output enables |
| pad_out | output | 24 | Pad output values |
| pad_oe | output | 24 | Pad output enables |
| alt_sel | output | 24 | High where a pin is in alternate mode |

## Verification
Some properties are checked by assertions on every cycle:
- A disabled port pair returns zero and leaves its latches and index untouched.
- An input pin outside alternate mode never drives.
- An alternate-mode pin's enable always matches its peripheral's enable.
- A placement write lands on the next edge.
- A data write through index 1, 2 or 3 lands in the matching latch.

The bench scenarios are needed for the rest:
- the polarity and readback mix across the direction and mode cases;
- relocation of the port pair to all four addresses;
- the irregular pin numbering and the register with a gap in it;
- unknown indexes and unmapped configuration addresses.

// File: rtl/idx_gpio_pkg.sv
package idx_gpio_pkg;

  localparam int unsigned BYTE_W = 8;

  // Index-port address of the pair for each placement code
  function automatic logic [BYTE_W-1:0] pair_base(input logic [1:0] sel);
    logic [BYTE_W-1:0] a;
    case (sel)
      2'd0:    a = 8'hE0;
      2'd1:    a = 8'hE2;
      2'd2:    a = 8'hE4;
      default: a = 8'hEA;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/gpio_cfg_file.sv
module gpio_cfg_file #(
  parameter int unsigned           GROUPS   = 3,
  parameter logic [GROUPS*8-1:0]   PIN_MASK = 24'hFF3FFF,
  parameter logic [GROUPS*8-1:0]   CFG_BASE = 24'hF5E8E0,
  parameter logic [7:0]            SEL_ADDR = 8'h03
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [7:0]            cfg_addr,
  input  logic [7:0]            cfg_wdata,
  output logic                  port_en,
  output logic [1:0]            port_sel,
  output logic [GROUPS*8-1:0]   dir_in,
  output logic [GROUPS*8-1:0]   inv,
  output logic [GROUPS*8-1:0]   spec
);
  localparam int unsigned NP = GROUPS * 8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_en  <= 1'b0;
      port_sel <= 2'd0;
    end else if (cfg_we && cfg_addr == SEL_ADDR) begin
      port_en  <= cfg_wdata[7];
      port_sel <= cfg_wdata[1:0];
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar b = 0; b < 8; b++) begin : g_pin
      localparam int unsigned K = g * 8 + b;
      if (PIN_MASK[K]) begin : g_live
        localparam logic [7:0] A = 8'(CFG_BASE[g*8 +: 8] + 8'(b));
        logic d_q, i_q, s_q;
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            d_q <= 1'b1;
            i_q <= 1'b0;
            s_q <= 1'b0;
          end else if (cfg_we && cfg_addr == A) begin
            d_q <= cfg_wdata[0];
            i_q <= cfg_wdata[1];
            s_q <= cfg_wdata[3];
          end
        end
        assign dir_in[K] = d_q;
        assign inv[K]    = i_q;
        assign spec[K]   = s_q;
      end else begin : g_dead
        assign dir_in[K] = 1'b1;
        assign inv[K]    = 1'b0;
        assign spec[K]   = 1'b0;
      end
    end
  end

  // R2: placement byte takes effect on the following edge
  p_sel_upd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == SEL_ADDR) |=> (port_en == $past(cfg_wdata[7]) &&
                                          port_sel == $past(cfg_wdata[1:0])));

  initial begin
    if (NP > 64) $error("too many pins");
  end
endmodule

// File: rtl/gpio_port_io.sv
module gpio_port_io
  import idx_gpio_pkg::*;
#(
  parameter int unsigned         GROUPS   = 3,
  parameter logic [GROUPS*8-1:0] PIN_MASK = 24'hFF3FFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                port_en,
  input  logic [1:0]          port_sel,
  input  logic [7:0]          io_addr,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [7:0]          io_wdata,
  output logic [7:0]          io_rdata,
  input  logic [GROUPS*8-1:0] pad_in,
  input  logic [GROUPS*8-1:0] dir_in,
  input  logic [GROUPS*8-1:0] inv,
  input  logic [GROUPS*8-1:0] spec,
  output logic [GROUPS*8-1:0] latch
);
  localparam int unsigned NP = GROUPS * 8;

  logic [7:0]    index_q;
  logic [7:0]    base;
  logic          hit_idx, hit_dat;
  logic [NP-1:0] rb;

  assign base    = pair_base(port_sel);
  assign hit_idx = port_en && (io_addr == base);
  assign hit_dat = port_en && (io_addr == 8'(base + 8'd1));

  always_ff @(posedge clk) begin
    if (!rst_n)               index_q <= 8'h00;
    else if (hit_idx && io_wr) index_q <= io_wdata;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_reg
    localparam logic [7:0] GI = 8'(g + 1);
    localparam logic [7:0] MG = PIN_MASK[g*8 +: 8];
    logic [7:0] grp_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 grp_q <= 8'h00;
      else if (hit_dat && io_wr && index_q == GI) grp_q <= io_wdata & MG;
    end
    assign latch[g*8 +: 8] = grp_q;

    // R4: a data write through index g+1 lands in that group's latch
    p_grp_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_dat && io_wr && index_q == GI) |=> (latch[g*8 +: 8] == ($past(io_wdata) & MG)));
  end

  // Per-pin readback: raw pad in alternate mode, corrected pad for inputs, latch for outputs
  assign rb = PIN_MASK & ((spec & pad_in) |
                          (~spec & dir_in & (pad_in ^ inv)) |
                          (~spec & ~dir_in & latch));

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd && hit_idx) begin
      io_rdata = index_q;
    end else if (io_rd && hit_dat) begin
      for (int g = 0; g < GROUPS; g++) begin
        if (index_q == 8'(g + 1)) io_rdata = rb[g*8 +: 8];
      end
    end
  end

  // R3: bus traffic on a disabled pair leaves latches and index untouched
  p_dis_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && io_wr) |=> ($stable(latch) && $stable(index_q)));
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int unsigned         GROUPS   = 3,
  parameter logic [GROUPS*8-1:0] PIN_MASK = 24'hFF3FFF
) (
  input  logic [GROUPS*8-1:0] latch,
  input  logic [GROUPS*8-1:0] dir_in,
  input  logic [GROUPS*8-1:0] inv,
  input  logic [GROUPS*8-1:0] spec,
  input  logic [GROUPS*8-1:0] alt_out,
  input  logic [GROUPS*8-1:0] alt_oe,
  output logic [GROUPS*8-1:0] pad_out,
  output logic [GROUPS*8-1:0] pad_oe,
  output logic [GROUPS*8-1:0] alt_sel
);
  localparam int unsigned NP = GROUPS * 8;

  for (genvar k = 0; k < NP; k++) begin : g_pin
    if (PIN_MASK[k]) begin : g_live
      assign pad_out[k] = spec[k] ? alt_out[k] : (latch[k] ^ inv[k]);
      assign pad_oe[k]  = spec[k] ? alt_oe[k]  : ~dir_in[k];
      assign alt_sel[k] = spec[k];
    end else begin : g_dead
      assign pad_out[k] = 1'b0;
      assign pad_oe[k]  = 1'b0;
      assign alt_sel[k] = 1'b0;
    end
  end
endmodule

// File: rtl/idx_gpio.sv
module idx_gpio #(
  parameter int unsigned         GROUPS   = 3,
  parameter logic [GROUPS*8-1:0] PIN_MASK = 24'hFF3FFF,
  parameter logic [GROUPS*8-1:0] CFG_BASE = 24'hF5E8E0,
  parameter logic [7:0]          SEL_ADDR = 8'h03
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [7:0]          cfg_addr,
  input  logic [7:0]          cfg_wdata,
  input  logic [7:0]          io_addr,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [7:0]          io_wdata,
  output logic [7:0]          io_rdata,
  input  logic [GROUPS*8-1:0] pad_in,
  input  logic [GROUPS*8-1:0] alt_out,
  input  logic [GROUPS*8-1:0] alt_oe,
  output logic [GROUPS*8-1:0] pad_out,
  output logic [GROUPS*8-1:0] pad_oe,
  output logic [GROUPS*8-1:0] alt_sel
);
  localparam int unsigned NP = GROUPS * 8;

  logic          port_en;
  logic [1:0]    port_sel;
  logic [NP-1:0] dir_in, inv, spec, latch;

  gpio_cfg_file #(.GROUPS(GROUPS), .PIN_MASK(PIN_MASK), .CFG_BASE(CFG_BASE),
                  .SEL_ADDR(SEL_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .port_en(port_en), .port_sel(port_sel),
    .dir_in(dir_in), .inv(inv), .spec(spec)
  );

  gpio_port_io #(.GROUPS(GROUPS), .PIN_MASK(PIN_MASK)) u_port (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .port_sel(port_sel),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .pad_in(pad_in), .dir_in(dir_in), .inv(inv),
    .spec(spec), .latch(latch)
  );

  gpio_pin_drive #(.GROUPS(GROUPS), .PIN_MASK(PIN_MASK)) u_drive (
    .latch(latch), .dir_in(dir_in), .inv(inv), .spec(spec),
    .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_sel(alt_sel)
  );

  // R3: a disabled pair reads as zero
  p_dis_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (io_rdata == 8'h00));

  // R7: an ordinary-mode input never drives its pad
  p_input_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_in & ~spec & pad_oe) == '0));

  // R10: alternate-mode pins follow the peripheral's enable
  p_alt_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ alt_oe) & spec) == '0));
endmodule

// File: tb/idx_gpio_bench.sv
`timescale 1ns/1ps
module idx_gpio_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0, cfg_wdata = '0;
  logic [7:0]  io_addr = '0, io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [23:0] pad_in = '0, alt_out = '0, alt_oe = '0;
  logic [23:0] pad_out, pad_oe, alt_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  idx_gpio u_idx_gpio (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pad_in(pad_in),
    .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_sel(alt_sel)
  );

  // Pin 12 scenarios: config byte, latch bit, pad, alt value, alt enable,
  // expected pad_out, pad_oe and readback bit
  typedef struct packed {
    logic [7:0] cfg;
    logic lat, pad, ao, aoe, eout, eoe, erd;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{8'h02, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{8'h08, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{8'h0B, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{8'hF4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  function automatic logic [7:0] bench_base(input int s);
    case (s)
      0: return 8'hE0;
      1: return 8'hE2;
      2: return 8'hE4;
      default: return 8'hEA;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    d = io_rdata;
    io_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pad_oe", pad_oe, 24'h0);
    chk("R1 alt_sel", alt_sel, 24'h0);
    chk("R1 pad_out", pad_out, 24'h0);
    bus_rd(8'hEB, rd);
    chk("R1 R3 disabled read", rd, 8'h00);

    // R2 placement of the pair at each of the four positions
    for (int s = 0; s < 4; s++) begin
      cfg_wr(8'h03, 8'h80 | 8'(s));
      bus_wr(bench_base(s), 8'h03);
      bus_rd(bench_base(s), rd);
      chk("R2 index readback", rd, 8'h03);
      bus_rd(bench_base((s + 1) % 4), rd);
      chk("R2 other pair silent", rd, 8'h00);
    end

    // Vector walk on pin 12 (bit 2) with pair at 0xEA/0xEB, index 1
    cfg_wr(8'h03, 8'h83);
    bus_wr(8'hEA, 8'h01);
    for (int i = 0; i < 9; i++) begin
      cfg_wr(8'hE2, VEC[i].cfg);
      pad_in  = {21'h0, VEC[i].pad, 2'b00};
      alt_out = {21'h0, VEC[i].ao, 2'b00};
      alt_oe  = {21'h0, VEC[i].aoe, 2'b00};
      bus_wr(8'hEB, {5'h0, VEC[i].lat, 2'b00});
      @(negedge clk);
      chk("R8 R10 pad_out pin12", pad_out[2], VEC[i].eout);
      chk("R7 R10 pad_oe pin12", pad_oe[2], VEC[i].eoe);
      chk("R10 alt_sel pin12", alt_sel[2], VEC[i].cfg[3]);
      bus_rd(8'hEB, rd);
      chk("R9 readback pin12", rd[2], VEC[i].erd);
    end
    pad_in = '0; alt_out = '0; alt_oe = '0;

    // R8: all of pins 10-17 as outputs
    for (int b = 0; b < 8; b++) cfg_wr(8'hE0 + 8'(b), 8'h00);
    bus_wr(8'hEB, 8'h5A);
    @(negedge clk);
    chk("R8 group 10-17 out", pad_out[7:0], 8'h5A);
    chk("R8 group 10-17 oe", pad_oe[7:0], 8'hFF);

    // R3: disabled pair ignores traffic
    cfg_wr(8'h03, 8'h03);
    bus_wr(8'hEB, 8'hFF);
    bus_wr(8'hEA, 8'h02);
    bus_rd(8'hEB, rd);
    chk("R3 read while off", rd, 8'h00);
    @(negedge clk);
    chk("R3 latch kept", pad_out[7:0], 8'h5A);
    cfg_wr(8'h03, 8'h83);
    bus_rd(8'hEA, rd);
    chk("R3 index kept", rd, 8'h01);
    bus_rd(8'hEB, rd);
    chk("R3 data kept", rd, 8'h5A);

    // R5: pins 20-25 with unused top bits
    for (int b = 0; b < 6; b++) cfg_wr(8'hE8 + 8'(b), 8'h00);
    bus_wr(8'hEA, 8'h02);
    bus_wr(8'hEB, 8'hFF);
    bus_rd(8'hEB, rd);
    chk("R5 group 20-25 read", rd, 8'h3F);
    @(negedge clk);
    chk("R5 group 20-25 out", pad_out[15:8], 8'h3F);
    chk("R5 group 20-25 oe", pad_oe[15:8], 8'h3F);
    bus_wr(8'hEA, 8'h04);
    bus_rd(8'hEB, rd);
    chk("R5 unknown index read", rd, 8'h00);
    bus_wr(8'hEB, 8'h11);
    bus_wr(8'hEA, 8'h00);
    bus_wr(8'hEB, 8'h22);
    @(negedge clk);
    chk("R5 unknown index write", pad_out, 24'h003F5A);

    // R6: unmapped config addresses, then pin 37
    cfg_wr(8'hEE, 8'h00);
    cfg_wr(8'hF4, 8'h00);
    cfg_wr(8'hFD, 8'h00);
    @(negedge clk);
    chk("R6 unmapped cfg", pad_oe[23:16], 8'h00);
    cfg_wr(8'hFC, 8'h00);
    @(negedge clk);
    chk("R6 pin 37 cfg", pad_oe[23:16], 8'h80);

    // R4: pins 30-37 through index 3, bit = pin mod 10
    for (int b = 0; b < 7; b++) cfg_wr(8'hF5 + 8'(b), 8'h00);
    bus_wr(8'hEA, 8'h03);
    bus_wr(8'hEB, 8'h81);
    @(negedge clk);
    chk("R4 group 30-37 out", pad_out[23:16], 8'h81);
    bus_rd(8'hEB, rd);
    chk("R4 group 30-37 read", rd, 8'h81);
    chk("R4 other groups intact", pad_out[15:0], 16'h3F5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule